// File: doc/BRIEF.md
# Gear-Shift Code Controller for a Digital Low-Dropout Regulator

This block drives the enable code of the segmented power array in a digital low-dropout regulator. A small analog stage runs in parallel with the array and carries whatever load current the array does not. A three-comparator flash converter senses that stage's current, and its 3-bit result is the only error input this controller sees. The controller reads the word on every clock edge and moves the array code to push the analog stage's current toward zero. When the analog stage sources current, the code rises. When it sinks current, the code falls.

The controller has two modes. While the comparators report a small error, it works in fine mode and takes single-LSB steps, or holds if the deadband option is set. When a load transient pushes the error past a threshold in the same direction on consecutive cycles, it shifts into gear mode. In gear mode the step doubles on each further out-of-band cycle, up to a programmable ceiling, so the code tracks the estimated load quickly. A reversal of the current's direction drops it back to fine mode. The code can be presented in binary or in thermometer form, chosen by a parameter.

Top module: `gsldo_ctrl`

## Requirements
- R1: While `rst_n` is low, `dac_code` equals `INIT_CODE`, `gear_mode` is 0 and `cmp_fault` is 0.
- R2: The comparator word is {upper, middle, lower}. Upper is 0 above the positive threshold, lower is 1 below the negative threshold, and middle is 0 when the analog stage sources current and 1 when it sinks. In fine mode with `deadband_en` low, the in-band word 3'b100 raises the code by 1 on the next edge and 3'b110 lowers it by 1.
- R3: In fine mode with `deadband_en` high, an in-band word (3'b100 or 3'b110) leaves the code unchanged.
- R4: An out-of-band word (3'b000 sourcing, 3'b111 sinking) that does not follow an out-of-band word of the same direction moves the code by 1 LSB in its direction.
- R5: An out-of-band word that directly follows a valid out-of-band word of the same direction sets `gear_mode`. The internal step doubles, is capped at `max_step` (0 is read as 1), and the code moves by the new step.
- R6: A valid word whose middle bit differs from the previous valid word's middle bit clears `gear_mode` and applies the fine-mode rule (R2, R3, R4) for that cycle.
- R7: In gear mode, a word with no direction change that does not double the step (an in-band word, or an out-of-band word after an in-band one) moves the code by the current step and keeps `gear_mode` set.
- R8: The code saturates at 0 and at 2^CODE_W-1, with no wraparound.
- R9: The words 3'b001, 3'b010, 3'b011 and 3'b101 are invalid. They leave the code, the mode and the step history unchanged, and they set `cmp_fault`, which stays set until reset.
- R10: While `en` is low, the code holds, `gear_mode` clears and the direction history is forgotten, so the first out-of-band word after re-enable moves the code by 1.
- R11: Take a plant whose comparators report in-band for an error of 8 LSB or less. With `max_step` set to 64, a target step from code 25 to code 230 brings the error into the band within 15 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the error is sampled and the code updated on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Loop enable; when low the code holds and the mode history clears |
| cmp_word | input | 3 | Comparator word {upper, middle, lower} |
| max_step | input | CODE_W | Ceiling for the gear-mode step, in LSBs |
| deadband_en | input | 1 | When high, fine mode holds on in-band words |
| dac_code | output | OUT_W | Array enable code: CODE_W bits binary, or 2^CODE_W-1 bits thermometer |
| gear_mode | output | 1 | High while the controller is in gear mode |
| cmp_fault | output | 1 | Sticky flag: an invalid comparator word was seen |

## Verification
The checker assumes that `cmp_word` is stable across each rising edge and that, outside the fault checks, it carries one of the four legal codes. The stimulus changes the word only on falling edges and applies the illegal codes only in dedicated steps. The per-step properties compare the binary code against its value one edge earlier. They assume that `max_step` does not change during a gear sequence, and the bench changes it only while reset is asserted. The settling check uses a bench plant that derives the comparator word from the distance between a fixed target and the current code.

// File: rtl/gsldo_pkg.sv
package gsldo_pkg;

   typedef enum logic [2:0] {
      ERR_BAND_SRC = 3'd0,
      ERR_BAND_SNK = 3'd1,
      ERR_BIG_SRC  = 3'd2,
      ERR_BIG_SNK  = 3'd3,
      ERR_BAD      = 3'd4
   } err_cls_e;

   function automatic logic cls_valid(err_cls_e c);
      return c != ERR_BAD;
   endfunction

   function automatic logic cls_big(err_cls_e c);
      return (c == ERR_BIG_SRC) || (c == ERR_BIG_SNK);
   endfunction

   function automatic logic cls_down(err_cls_e c);
      return (c == ERR_BAND_SNK) || (c == ERR_BIG_SNK);
   endfunction

endpackage

// File: rtl/gsldo_decode.sv
module gsldo_decode
   import gsldo_pkg::*;
(
   input  logic [2:0] cmp_word,
   output err_cls_e   cls
);

   always_comb begin
      unique case (cmp_word)
         3'b100:  cls = ERR_BAND_SRC;
         3'b110:  cls = ERR_BAND_SNK;
         3'b000:  cls = ERR_BIG_SRC;
         3'b111:  cls = ERR_BIG_SNK;
         default: cls = ERR_BAD;
      endcase
   end

endmodule

// File: rtl/gsldo_gear.sv
module gsldo_gear
   import gsldo_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  err_cls_e          cls,
   input  logic [CODE_W-1:0] max_step,
   input  logic              deadband_en,
   output logic [CODE_W-1:0] amt,
   output logic              dn,
   output logic              gear_mode
);

   localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

   logic [CODE_W-1:0] step_q, step_n, amt_n, cap;
   logic [CODE_W:0]   dbl;
   logic [CODE_W-1:0] dbl_cap;
   logic              gear_q, gear_n;
   logic              last_big_q, last_dn_q, hist_q;
   logic              valid, big, flip;

   assign valid = cls_valid(cls);
   assign big   = cls_big(cls);
   assign dn    = cls_down(cls);
   assign flip  = hist_q && (dn != last_dn_q);
   assign cap   = (max_step == '0) ? ONE : max_step;
   assign dbl   = {step_q, 1'b0};
   assign dbl_cap = (dbl > {1'b0, cap}) ? cap : dbl[CODE_W-1:0];

   always_comb begin
      if (big && last_big_q && !flip) begin
         step_n = dbl_cap;
         amt_n  = dbl_cap;
         gear_n = 1'b1;
      end else if (gear_q && !flip) begin
         step_n = step_q;
         amt_n  = step_q;
         gear_n = 1'b1;
      end else begin
         step_n = ONE;
         amt_n  = (big || !deadband_en) ? ONE : '0;
         gear_n = 1'b0;
      end
   end

   assign amt       = (en && valid) ? amt_n : '0;
   assign gear_mode = gear_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q     <= ONE;
         gear_q     <= 1'b0;
         last_big_q <= 1'b0;
         last_dn_q  <= 1'b0;
         hist_q     <= 1'b0;
      end else if (!en) begin
         step_q     <= ONE;
         gear_q     <= 1'b0;
         last_big_q <= 1'b0;
         hist_q     <= 1'b0;
      end else if (valid) begin
         step_q     <= step_n;
         gear_q     <= gear_n;
         last_big_q <= big;
         last_dn_q  <= dn;
         hist_q     <= 1'b1;
      end
   end

endmodule

// File: rtl/gsldo_accum.sv
module gsldo_accum #(
   parameter int CODE_W    = 8,
   parameter int INIT_CODE = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] amt,
   input  logic              dn,
   output logic [CODE_W-1:0] code
);

   localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

   logic [CODE_W-1:0] code_q, code_n;
   logic [CODE_W:0]   sum;

   assign sum = {1'b0, code_q} + {1'b0, amt};

   always_comb begin
      if (dn)
         code_n = (code_q < amt) ? '0 : code_q - amt;
      else
         code_n = sum[CODE_W] ? FULL : sum[CODE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= CODE_W'(INIT_CODE);
      else        code_q <= code_n;
   end

   assign code = code_q;

endmodule

// File: rtl/gsldo_outenc.sv
module gsldo_outenc #(
   parameter int CODE_W = 8,
   parameter bit THERMO = 1'b0,
   parameter int OUT_W  = THERMO ? (1 << CODE_W) - 1 : CODE_W
) (
   input  logic [CODE_W-1:0] code,
   output logic [OUT_W-1:0]  dac
);

   generate
      if (THERMO) begin : g_therm
         for (genvar i = 0; i < OUT_W; i++) begin : g_seg
            assign dac[i] = ({1'b0, code} > (CODE_W+1)'(i));
         end
      end else begin : g_bin
         assign dac = code;
      end
   endgenerate

endmodule

// File: rtl/gsldo_ctrl.sv
module gsldo_ctrl
   import gsldo_pkg::*;
#(
   parameter int CODE_W    = 8,
   parameter int INIT_CODE = 128,
   parameter bit THERMO    = 1'b0,
   parameter int OUT_W     = THERMO ? (1 << CODE_W) - 1 : CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [2:0]        cmp_word,
   input  logic [CODE_W-1:0] max_step,
   input  logic              deadband_en,
   output logic [OUT_W-1:0]  dac_code,
   output logic              gear_mode,
   output logic              cmp_fault
);

   localparam int FULL_VAL = (1 << CODE_W) - 1;

   generate
      if (CODE_W < 2 || CODE_W > 12) begin : g_bad_width
         $error("gsldo_ctrl: CODE_W must lie in 2..12");
      end
      if (INIT_CODE < 0 || INIT_CODE > FULL_VAL) begin : g_bad_init
         $error("gsldo_ctrl: INIT_CODE outside code range");
      end
      if (OUT_W != (THERMO ? FULL_VAL : CODE_W)) begin : g_bad_outw
         $error("gsldo_ctrl: OUT_W does not match the output encoding");
      end
   endgenerate

   err_cls_e          cls;
   logic [CODE_W-1:0] amt, code_q;
   logic              dn;
   logic              fault_q;

   gsldo_decode u_dec (
      .cmp_word (cmp_word),
      .cls      (cls)
   );

   gsldo_gear #(.CODE_W(CODE_W)) u_gear (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (en),
      .cls         (cls),
      .max_step    (max_step),
      .deadband_en (deadband_en),
      .amt         (amt),
      .dn          (dn),
      .gear_mode   (gear_mode)
   );

   gsldo_accum #(.CODE_W(CODE_W), .INIT_CODE(INIT_CODE)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .amt   (amt),
      .dn    (dn),
      .code  (code_q)
   );

   gsldo_outenc #(.CODE_W(CODE_W), .THERMO(THERMO), .OUT_W(OUT_W)) u_enc (
      .code (code_q),
      .dac  (dac_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          fault_q <= 1'b0;
      else if (en && !cls_valid(cls))      fault_q <= 1'b1;
   end

   assign cmp_fault = fault_q;

endmodule

// File: rtl/gsldo_ctrl_chk.sv
module gsldo_ctrl_chk #(
   parameter int CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [2:0]        cmp_word,
   input logic              deadband_en,
   input logic [CODE_W-1:0] code,
   input logic              gear_mode,
   input logic              cmp_fault
);

   localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

   logic legal, out_band;
   assign legal    = (cmp_word == 3'b100) || (cmp_word == 3'b110) ||
                     (cmp_word == 3'b000) || (cmp_word == 3'b111);
   assign out_band = (cmp_word == 3'b000) || (cmp_word == 3'b111);

   assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_fault |=> cmp_fault);

   assert_bad_word_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !legal) |=> ($stable(code) && $stable(gear_mode) && cmp_fault));

   assert_disabled_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(code) && !gear_mode));

   assert_fine_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !gear_mode && !deadband_en && cmp_word == 3'b100 && code != FULL)
      |=> (code == $past(code) + CODE_W'(1)));

   assert_fine_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !gear_mode && !deadband_en && cmp_word == 3'b110 && code != '0)
      |=> (code == $past(code) - CODE_W'(1)));

   assert_deadband_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !gear_mode && deadband_en && legal && !out_band) |=> $stable(code));

   assert_gear_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gear_mode) |-> ($past(cmp_word) == 3'b000 || $past(cmp_word) == 3'b111));

endmodule

bind gsldo_ctrl gsldo_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .cmp_word    (cmp_word),
   .deadband_en (deadband_en),
   .code        (code_q),
   .gear_mode   (gear_mode),
   .cmp_fault   (cmp_fault)
);

// File: tb/gsldo_ctrl_test.sv
module gsldo_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [2:0] cmp = 3'b100;
   logic [7:0] mstep = 8'd8;
   logic       db = 1'b0;
   logic [7:0] code;
   logic       gear, fault;

   logic [2:0] s_cmp;
   logic [7:0] s_code;
   logic       s_gear, s_fault;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   gsldo_ctrl uut (
      .clk(clk), .rst_n(rst_n), .en(en), .cmp_word(cmp), .max_step(mstep),
      .deadband_en(db), .dac_code(code), .gear_mode(gear), .cmp_fault(fault));

   gsldo_ctrl #(.INIT_CODE(25)) uut_settle (
      .clk(clk), .rst_n(rst_n), .en(1'b1), .cmp_word(s_cmp), .max_step(8'd64),
      .deadband_en(1'b0), .dac_code(s_code), .gear_mode(s_gear), .cmp_fault(s_fault));

   // bench plant for the settling check: target 230, band of 8 LSB
   always_comb begin
      int err;
      err = 230 - int'(s_code);
      if (err > 8)       s_cmp = 3'b000;
      else if (err < -8) s_cmp = 3'b111;
      else if (err >= 0) s_cmp = 3'b100;
      else               s_cmp = 3'b110;
   end

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(logic [2:0] w, logic d, logic e);
      @(negedge clk);
      cmp = w; db = d; en = e;
      @(posedge clk);
      #1;
   endtask

   // {req, cmp, deadband, expected code, expected gear}; start code 128, max_step 8
   localparam logic [16:0] VEC [17] = '{
      {4'd2,  3'b100, 1'b0, 8'd129, 1'b0},  // R2 up
      {4'd2,  3'b110, 1'b0, 8'd128, 1'b0},  // R2 down
      {4'd3,  3'b110, 1'b1, 8'd128, 1'b0},  // R3 hold
      {4'd3,  3'b100, 1'b1, 8'd128, 1'b0},  // R3 hold
      {4'd4,  3'b000, 1'b0, 8'd129, 1'b0},  // R4 first out-of-band
      {4'd5,  3'b000, 1'b0, 8'd131, 1'b1},  // R5 step 2
      {4'd5,  3'b000, 1'b0, 8'd135, 1'b1},  // R5 step 4
      {4'd5,  3'b000, 1'b0, 8'd143, 1'b1},  // R5 step 8
      {4'd5,  3'b000, 1'b0, 8'd151, 1'b1},  // R5 capped at 8
      {4'd7,  3'b100, 1'b0, 8'd159, 1'b1},  // R7 in-band keeps step
      {4'd7,  3'b000, 1'b0, 8'd167, 1'b1},  // R7 no doubling after in-band
      {4'd6,  3'b110, 1'b0, 8'd166, 1'b0},  // R6 reversal
      {4'd4,  3'b111, 1'b0, 8'd165, 1'b0},  // R4 down
      {4'd5,  3'b111, 1'b0, 8'd163, 1'b1},  // R5 step 2 down
      {4'd9,  3'b010, 1'b0, 8'd163, 1'b1},  // R9 invalid holds
      {4'd9,  3'b111, 1'b0, 8'd159, 1'b1},  // R9 history kept: step 4
      {4'd9,  3'b101, 1'b0, 8'd159, 1'b1}   // R9 invalid holds
   };

   initial begin
      #2000000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int hit;
      #7;
      check("R1 code", code, 128);
      check("R1 gear", gear, 0);
      check("R1 fault", fault, 0);
      check("R1 settle-inst code", s_code, 25);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: settling from 25 toward 230
      hit = 0;
      for (int c = 1; c <= 30; c++) begin
         @(posedge clk); #1;
         if (hit == 0 && (int'(s_code) >= 222 && int'(s_code) <= 238)) hit = c;
      end
      total++;
      if (hit == 0 || hit > 15) begin
         bad++;
         $display("FAIL R11 actual=%0d expected<=15 cycles", hit);
      end

      for (int i = 0; i < 17; i++) begin
         step(VEC[i][12:10], VEC[i][9], 1'b1);
         check($sformatf("R%0d code vec%0d", VEC[i][16:13], i), code, VEC[i][8:1]);
         check($sformatf("R%0d gear vec%0d", VEC[i][16:13], i), gear, VEC[i][0]);
      end
      check("R9 fault sticky", fault, 1);
      step(3'b100, 1'b0, 1'b1);
      check("R9 fault stays", fault, 1);

      // reset clears fault; R8 saturation with max_step 64
      @(negedge clk); rst_n = 1'b0; mstep = 8'd64; #1;
      check("R1 fault cleared", fault, 0);
      check("R1 code back", code, 128);
      @(negedge clk); rst_n = 1'b1;
      for (int i = 0; i < 12; i++) step(3'b000, 1'b0, 1'b1);
      check("R8 top saturation", code, 255);
      check("R8 gear at top", gear, 1);
      for (int i = 0; i < 14; i++) step(3'b111, 1'b0, 1'b1);
      check("R8 bottom saturation", code, 0);

      // R10: enable low
      step(3'b000, 1'b0, 1'b0);
      check("R10 code held", code, 0);
      check("R10 gear cleared", gear, 0);
      step(3'b000, 1'b0, 1'b0);
      check("R10 still held", code, 0);
      step(3'b000, 1'b0, 1'b1);
      check("R10 first step after enable", code, 1);
      check("R10 gear after enable", gear, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule